// File: doc/BRIEF.md
# Go-Back Link Retransmission Sender

This block is the transmit half of a point-to-point link between two neighbouring switches. The link guards its flits with positive and negative acknowledgements from the far end. Upstream logic offers flits through a valid/ready handshake. The sender writes every accepted flit into a small replay store and sends it on the link with a sequence number. It keeps that copy until the receiver confirms the flit.

A positive acknowledgement names the oldest outstanding sequence number and frees that slot. A negative acknowledgement names a flit that arrived damaged. The sender then moves its transmit point back to that flit and sends it again, followed by every later flit in their original order. While this replay runs, upstream flits are held off. The store depth follows from the link's round trip. It is at least twice the number of buffer stages on the hop plus the logic latency at both ends, rounded up to a power of two.

Top module: `gbn_link_sender`

## Requirements
- R1: After reset, no flit is held, `out_valid` is 0, `in_ready` is 1, and the first flit accepted afterwards is sent with sequence number 0.
- R2: Accepted flits leave the link in acceptance order. A flit accepted at a clock edge is presented from the next cycle. Consecutive transmissions carry consecutive sequence numbers modulo 2^SEQ_W. SEQ_W = log2(DEPTH)+1 and DEPTH = 2·HOP_STAGES+LOGIC_LAT rounded up to a power of two, which gives DEPTH 8 and SEQ_W 4 at the defaults.
- R3: A positive acknowledgement (`ack_valid`=1, `ack_is_nack`=0) whose `ack_seq` equals the oldest unacknowledged, already-sent sequence number frees that one entry.
- R4: A positive acknowledgement with any other `ack_seq`, or one for a flit not yet sent, has no effect: the output stream and `in_ready` behave as if it never came.
- R5: When DEPTH flits are unacknowledged, `in_ready` is 0 and no flit is accepted.
- R6: A negative acknowledgement (`ack_is_nack`=1) whose `ack_seq` lies among the sent, unacknowledged flits makes the next cycle present that sequence number again. All later stored flits follow in order, and all entries older than it are freed.
- R7: A negative acknowledgement whose `ack_seq` does not lie among the sent, unacknowledged flits is ignored.
- R8: From an accepted negative acknowledgement until the last stored flit has been resent, `in_ready` is 0.
- R9: A negative acknowledgement accepted while a replay is still running restarts the replay from the newly reported sequence number.
- R10: The link output is never idle while a stored flit remains unsent: `out_valid` is 1 in each such cycle and the transmit point advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream offers a flit |
| in_ready | output | 1 | Sender accepts the offered flit this cycle |
| in_flit | input | FLIT_W | Upstream flit payload |
| out_valid | output | 1 | A flit is driven on the link this cycle |
| out_flit | output | FLIT_W | Flit driven on the link |
| out_seq | output | SEQ_W | Sequence number of the flit on the link |
| ack_valid | input | 1 | An acknowledgement arrives from the receiver |
| ack_is_nack | input | 1 | 1: negative acknowledgement, 0: positive |
| ack_seq | input | SEQ_W | Sequence number the acknowledgement refers to |

## Verification
The bench attacks the window edges. It sends a duplicate positive acknowledgement, one for an unsent flit and one out of order. A design that accepted any of these would free a live copy, and a later replay would then send wrong data. It fills the store while upstream keeps pushing, so an off-by-one full test would overwrite an unacknowledged flit. It also issues a negative acknowledgement in the middle of the window, a second one during the replay, and one outside the window. A wrong design would resend from the wrong place, let fresh flits in between replayed ones, or rewind on a bogus report.

// File: rtl/gbn_pkg.sv
package gbn_pkg;

   typedef enum logic {
      ACK_POS = 1'b0,
      ACK_NEG = 1'b1
   } ack_kind_e;

   // smallest power of two not below v
   function automatic int unsigned pow2_ceil(input int unsigned v);
      int unsigned r;
      r = 1;
      for (int i = 0; i < 31; i++) begin
         if (r < v) r = r << 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/gbn_replay_store.sv
module gbn_replay_store #(
   parameter int FLIT_W = 16,
   parameter int DEPTH  = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [FLIT_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [FLIT_W-1:0] rd_data
);

   logic [DEPTH-1:0][FLIT_W-1:0] slots;

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic [FLIT_W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IDX_W'(e))) q <= wr_data;
      end
      assign slots[e] = q;
   end

   assign rd_data = slots[rd_idx];

endmodule

// File: rtl/gbn_seq_ctrl.sv
module gbn_seq_ctrl #(
   parameter int DEPTH  = 8,
   localparam int SEQ_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   output logic             wr_en,
   output logic [SEQ_W-1:0] wr_seq,
   output logic             out_valid,
   output logic [SEQ_W-1:0] send_seq,
   input  logic             ack_valid,
   input  gbn_pkg::ack_kind_e ack_kind,
   input  logic [SEQ_W-1:0] ack_seq
);
   import gbn_pkg::*;

   localparam logic [SEQ_W-1:0] DEPTH_V = SEQ_W'(DEPTH);

   logic [SEQ_W-1:0] oldest_q, send_q, tail_q;
   logic             replay_q;
   logic [SEQ_W-1:0] held, sent, ack_off;
   logic             pos_ok, neg_ok, full;

   assign held    = tail_q - oldest_q;
   assign sent    = send_q - oldest_q;
   assign ack_off = ack_seq - oldest_q;
   assign full    = (held == DEPTH_V);

   assign out_valid = (send_q != tail_q);
   assign send_seq  = send_q;
   assign wr_seq    = tail_q;
   assign in_ready  = !full && !replay_q;
   assign wr_en     = in_valid && in_ready;

   assign pos_ok = ack_valid && (ack_kind == ACK_POS) && (ack_off == '0) && (sent != '0);
   assign neg_ok = ack_valid && (ack_kind == ACK_NEG) && (ack_off < sent);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oldest_q <= '0;
         send_q   <= '0;
         tail_q   <= '0;
         replay_q <= 1'b0;
      end else begin
         if (wr_en) tail_q <= tail_q + 1'b1;
         if (neg_ok) begin
            oldest_q <= ack_seq;
            send_q   <= ack_seq;
            replay_q <= 1'b1;
         end else begin
            if (pos_ok)    oldest_q <= oldest_q + 1'b1;
            if (out_valid) send_q   <= send_q + 1'b1;
            if (replay_q && (send_q + 1'b1 == tail_q)) replay_q <= 1'b0;
         end
      end
   end

   // R5: the window never holds more than DEPTH flits, and never more sent than held
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (held <= DEPTH_V) && (sent <= held));

   // R2, R10: without a rewind, the transmit sequence steps by exactly one
   assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !neg_ok) |=> (!out_valid || (send_seq == SEQ_W'($past(send_seq) + 1'b1))));

   // R6, R9: an accepted rewind presents the reported flit on the next cycle
   assert_rewind_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      neg_ok |=> (out_valid && (send_seq == $past(ack_seq))));

   // R8: during a replay there is always something left to resend
   assert_replay_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      replay_q |-> out_valid);

   // R3: a freed entry must already have been sent
   assert_release_sent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pos_ok |=> (oldest_q != tail_q || send_q == tail_q));

endmodule

// File: rtl/gbn_link_sender.sv
module gbn_link_sender
   import gbn_pkg::*;
#(
   parameter int FLIT_W     = 16,
   parameter int HOP_STAGES = 2,
   parameter int LOGIC_LAT  = 2,
   localparam int DEPTH     = int'(pow2_ceil(2 * HOP_STAGES + LOGIC_LAT)),
   localparam int IDX_W     = $clog2(DEPTH),
   localparam int SEQ_W     = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [FLIT_W-1:0] in_flit,
   output logic              out_valid,
   output logic [FLIT_W-1:0] out_flit,
   output logic [SEQ_W-1:0]  out_seq,
   input  logic              ack_valid,
   input  logic              ack_is_nack,
   input  logic [SEQ_W-1:0]  ack_seq
);

   if (FLIT_W < 1) begin : g_bad_width
      $error("FLIT_W must be positive");
   end
   if (HOP_STAGES < 1 || LOGIC_LAT < 0) begin : g_bad_latency
      $error("HOP_STAGES must be at least 1 and LOGIC_LAT non-negative");
   end

   logic             wr_en;
   logic [SEQ_W-1:0] wr_seq;
   logic [SEQ_W-1:0] send_seq;
   ack_kind_e        ack_kind;

   assign ack_kind = ack_is_nack ? ACK_NEG : ACK_POS;
   assign out_seq  = send_seq;

   gbn_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .wr_en     (wr_en),
      .wr_seq    (wr_seq),
      .out_valid (out_valid),
      .send_seq  (send_seq),
      .ack_valid (ack_valid),
      .ack_kind  (ack_kind),
      .ack_seq   (ack_seq)
   );

   gbn_replay_store #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_seq[IDX_W-1:0]),
      .wr_data (in_flit),
      .rd_idx  (send_seq[IDX_W-1:0]),
      .rd_data (out_flit)
   );

endmodule

// File: tb/gbn_link_sender_test.sv
`timescale 1ns/1ps
module gbn_link_sender_test;

   localparam int FW  = 16;
   localparam int DEP = 8;
   localparam int MODW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [FW-1:0] in_flit = '0;
   logic          out_valid;
   logic [FW-1:0] out_flit;
   logic [3:0]    out_seq;
   logic          ack_valid = 1'b0;
   logic          ack_is_nack = 1'b0;
   logic [3:0]    ack_seq = '0;

   always #2 clk = ~clk;

   gbn_link_sender uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
      .out_valid(out_valid), .out_flit(out_flit), .out_seq(out_seq),
      .ack_valid(ack_valid), .ack_is_nack(ack_is_nack), .ack_seq(ack_seq)
   );

   // behavioural reference: absolute counters, never wrapped
   int m_ack = 0, m_send = 0, m_tail = 0;
   bit m_replay = 0;
   int m_data [1024];
   int n_cmp = 0, n_bad = 0, flit_ctr = 1;
   bit done = 0;
   string cur_req = "R1";

   int  p_sent, p_off;
   bit  p_wr, p_ov, p_pos, p_neg;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ack = 0; m_send = 0; m_tail = 0; m_replay = 0;
      end else begin
         p_sent = m_send - m_ack;
         p_wr   = in_valid && (m_tail - m_ack < DEP) && !m_replay;
         p_ov   = m_send < m_tail;
         p_off  = (int'(ack_seq) - (m_ack % MODW) + MODW) % MODW;
         p_pos  = ack_valid && !ack_is_nack && p_off == 0 && p_sent > 0;
         p_neg  = ack_valid && ack_is_nack && p_off < p_sent;
         if (p_wr) begin
            m_data[m_tail % 1024] = int'(in_flit);
            m_tail++;
         end
         if (p_neg) begin
            m_ack    = m_ack + p_off;
            m_send   = m_ack;
            m_replay = 1;
         end else begin
            if (p_ov) m_send++;
            if (p_pos) m_ack++;
            if (m_replay && m_send == m_tail) m_replay = 0;
         end
      end
   end

   task automatic check(input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      bit ev;
      ev = (m_send < m_tail);
      check("in_ready", int'(in_ready), int'((m_tail - m_ack < DEP) && !m_replay));
      check("out_valid", int'(out_valid), int'(ev));
      if (ev) begin
         check("out_seq", int'(out_seq), m_send % MODW);
         check("out_flit", int'(out_flit), m_data[m_send % 1024]);
      end
   endtask

   // kind: 0 none, 1 positive ack at oldest+off, 2 negative ack at oldest+off
   task automatic step(input bit iv, input int kind, input int off);
      @(negedge clk);
      compare();
      in_valid    = iv;
      in_flit     = FW'(flit_ctr * 37 + 5);
      flit_ctr++;
      ack_valid   = (kind != 0);
      ack_is_nack = (kind == 2);
      ack_seq     = 4'(((m_ack + off) % MODW + MODW) % MODW);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      check("reset in_ready", int'(in_ready), 1);
      check("reset out_valid", int'(out_valid), 0);
      step(1, 0, 0);
      @(negedge clk);
      check("first seq", int'(out_seq), 0);
      compare();

      cur_req = "R2";
      for (int i = 0; i < 4; i++) step(1, 0, 0);
      cur_req = "R10";
      for (int i = 0; i < 3; i++) step(0, 0, 0);

      cur_req = "R3";
      for (int i = 0; i < 5; i++) step(0, 1, 0);

      cur_req = "R4";
      step(0, 1, 3);          // nothing outstanding
      step(0, 1, -1);         // duplicate of a freed entry
      step(1, 0, 0);
      step(1, 0, 0);
      step(0, 1, 1);          // out of order
      step(0, 1, 5);          // beyond what was sent
      step(0, 0, 0);
      step(0, 1, 0);
      step(0, 1, 0);

      cur_req = "R5";
      for (int i = 0; i < 12; i++) step(1, 0, 0);
      @(negedge clk);
      check("full in_ready", int'(in_ready), 0);
      compare();
      step(1, 1, -2);         // stale ack while full

      cur_req = "R6";
      step(1, 2, 3);
      cur_req = "R8";
      for (int i = 0; i < 3; i++) step(1, 0, 0);
      cur_req = "R9";
      step(1, 2, 1);
      cur_req = "R8";
      for (int i = 0; i < 8; i++) step(1, 0, 0);

      cur_req = "R7";
      step(0, 2, 12);
      step(0, 0, 0);
      step(0, 2, 9);

      cur_req = "R3";
      for (int i = 0; i < 16; i++) step(0, 1, 0);
      cur_req = "R2";
      for (int i = 0; i < 6; i++) step(1, 0, 0);
      cur_req = "R6";
      step(0, 2, 0);
      cur_req = "R10";
      for (int i = 0; i < 10; i++) step(0, 1, 0);
      step(0, 0, 0);

      done = 1;
      summary();
      $finish;
   end

endmodule